// File: doc/BRIEF.md
# Video Sync Mode Classifier

This block identifies the display mode of an analog-style video source from its two sync wires alone. It runs on a free-running reference clock that has no relation to the source. It times the interval between active horizontal sync edges in reference clocks. It also counts how many horizontal sync edges occur between active vertical sync edges. Both figures are then compared against a small built-in table of known modes.

The nearest table entry is reported as a mode index. The block also outputs the full line total of that entry: active pixels, both porches and sync together. A downstream pixel clock multiplier uses this value as its feedback divider.

The sync polarity of each wire is found automatically, so either polarity works. A lock flag rises only after the result has held steady for several frames. A separate flag reports a missing or stalled source.

Top module: `sync_mode_classifier`

## Requirements
- R1: The line period is the number of reference clocks between two successive active edges of horizontal sync.
- R2: The lines-per-frame figure is the number of active horizontal sync edges seen between two successive active vertical sync edges.
- R3: The chosen entry has the smallest absolute line-period difference. A tie on that difference goes to the entry with the smaller absolute line-count difference. A tie on both goes to the lower index. The expected period of entry i is floor(REF_KHZ * htotal_i / pixel_kHz_i).
- R4: A frame is rejected when the chosen entry's line-period difference exceeds HTOL. It is also rejected when the line-count difference exceeds VTOL. Both measurements must therefore agree with a single entry.
- R5: The table holds four modes, given as index: htotal / vtotal / pixel clock. They are 0: 800/525/25175 kHz, 1: 1056/628/40000 kHz, 2: 1344/806/65000 kHz, and 3: 1800/1000/108000 kHz. Mode 3 is the 1280x960 mode, whose line has its sync from clock 1376 to 1488. `line_total_o` reports the htotal of the locked entry, which is never the visible width.
- R6: The active level of each sync wire is the level whose most recent phase was shorter, with high chosen on a tie. Edges are taken at the start of the active phase, so sources with either polarity classify identically.
- R7: `valid_o` rises only after QUAL_FRAMES (3) consecutive frames give an accepted result with the same index. It does not rise earlier.
- R8: Once valid, any frame that is rejected or picks a different index clears `valid_o`. `mode_idx_o` does not change while `valid_o` stays high.
- R9: `no_signal_o` is high while the line-period counter sits at HMAX or the line counter sits at VMAX. While it is high, `valid_o` is cleared. A returning horizontal sync clears the period part of the condition.
- R10: During and after reset, `valid_o`, `no_signal_o`, `mode_idx_o` and `line_total_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_in | input | 1 | Horizontal sync from the source, either polarity |
| vsync_in | input | 1 | Vertical sync from the source, either polarity |
| mode_idx_o | output | 2 | Index of the locked table entry |
| valid_o | output | 1 | Classification locked |
| no_signal_o | output | 1 | Sync missing: a measurement counter is saturated |
| line_total_o | output | 12 | Total clocks per line of the locked entry, for the pixel clock divider |

## Verification
The embedded properties watch the per-cycle rules on every cycle. They check that each counter restarts on its sync edge and that the period counter never passes its ceiling. They check that the selected entry is never beaten by another entry, that the lock flag only moves on a frame edge or a no-signal condition, and that the index stays fixed while locked. Other behaviour shows only in the bench's multi-frame scenarios. These scenarios cover the frame-count qualification, the polarity detection on inverted sources and the tie-break between equally distant periods. They also cover rejection when only one measurement fits, and the two saturation paths to no-signal.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int NMODES = 4;
  localparam int IW     = 2;
  localparam int DIVW   = 12;

  function automatic int mode_htotal(input int i);
    case (i)
      0:       return 800;
      1:       return 1056;
      2:       return 1344;
      default: return 1800;
    endcase
  endfunction

  function automatic int mode_vtotal(input int i);
    case (i)
      0:       return 525;
      1:       return 628;
      2:       return 806;
      default: return 1000;
    endcase
  endfunction

  function automatic int mode_pix_khz(input int i);
    case (i)
      0:       return 25175;
      1:       return 40000;
      2:       return 65000;
      default: return 108000;
    endcase
  endfunction
endpackage

// File: rtl/smc_sync_edge.sv
// Registers one sync wire, learns its active level from phase lengths,
// and pulses at the start of each active phase.
module smc_sync_edge #(
  parameter int PLW = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic edge_o
);
  logic           d1, d2;
  logic [PLW-1:0] run_q, run_n;
  logic [PLW-1:0] hi_q, hi_n, lo_q, lo_n;
  logic           act_high;

  always_comb begin
    run_n = (run_q == '1) ? run_q : run_q + 1'b1;
    hi_n  = hi_q;
    lo_n  = lo_q;
    if (d1 != d2) begin
      run_n = {{(PLW-1){1'b0}}, 1'b1};
      if (d2) hi_n = run_q;
      else    lo_n = run_q;
    end
  end

  assign act_high = (hi_q <= lo_q);
  assign edge_o   = (d1 == act_high) && (d2 != act_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1    <= 1'b0;
      d2    <= 1'b0;
      run_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      d1    <= sync_i;
      d2    <= d1;
      run_q <= run_n;
      hi_q  <= hi_n;
      lo_q  <= lo_n;
    end
  end
endmodule

// File: rtl/smc_meter.sv
// Line period timer and lines-per-frame counter with saturation detect.
module smc_meter #(
  parameter  int HMAX = 4095,
  parameter  int VMAX = 2047,
  localparam int HW   = $clog2(HMAX + 1),
  localparam int VW   = $clog2(VMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_edge_i,
  input  logic          vs_edge_i,
  output logic [HW-1:0] per_o,
  output logic [VW-1:0] lines_o,
  output logic          frame_o,
  output logic          nosig_o
);
  logic [HW-1:0] hcnt, hcnt_n, per_q, per_n;
  logic [VW-1:0] vcnt, vcnt_n;
  logic          hsat, vsat;

  assign hsat = (hcnt == HW'(HMAX));
  assign vsat = (vcnt == VW'(VMAX));

  always_comb begin
    hcnt_n = hsat ? hcnt : hcnt + 1'b1;
    per_n  = per_q;
    if (hs_edge_i) begin
      hcnt_n = {{(HW-1){1'b0}}, 1'b1};
      per_n  = hcnt;
    end
    vcnt_n = vcnt;
    if (vs_edge_i)
      vcnt_n = hs_edge_i ? {{(VW-1){1'b0}}, 1'b1} : '0;
    else if (hs_edge_i && !vsat)
      vcnt_n = vcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      per_q <= '0;
      vcnt  <= '0;
    end else begin
      hcnt  <= hcnt_n;
      per_q <= per_n;
      vcnt  <= vcnt_n;
    end
  end

  assign per_o   = per_q;
  assign lines_o = vcnt;
  assign frame_o = vs_edge_i;
  assign nosig_o = hsat || vsat;

  assert_period_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge_i |=> (hcnt == {{(HW-1){1'b0}}, 1'b1}));
  assert_line_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge_i |=> (vcnt <= {{(VW-1){1'b0}}, 1'b1}));
  assert_hcnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hcnt) <= HMAX);
endmodule

// File: rtl/smc_match.sv
// Nearest-entry search over the mode table.
module smc_match
  import smc_pkg::*;
#(
  parameter int REF_KHZ = 27000,
  parameter int HTOL    = 4,
  parameter int VTOL    = 4,
  parameter int HW      = 12,
  parameter int VW      = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] per_i,
  input  logic [VW-1:0] lines_i,
  output logic [IW-1:0] idx_o,
  output logic          ok_o
);
  logic [HW-1:0] exp_per [NMODES];
  logic [VW-1:0] exp_lin [NMODES];
  logic [HW-1:0] dh [NMODES];
  logic [VW-1:0] dv [NMODES];
  logic [HW-1:0] best_dh;
  logic [VW-1:0] best_dv;

  for (genvar g = 0; g < NMODES; g++) begin : g_entry
    localparam int EP = (REF_KHZ * mode_htotal(g)) / mode_pix_khz(g);
    localparam int EL = mode_vtotal(g);
    assign exp_per[g] = HW'(EP);
    assign exp_lin[g] = VW'(EL);
    assign dh[g] = (per_i >= exp_per[g]) ? per_i - exp_per[g] : exp_per[g] - per_i;
    assign dv[g] = (lines_i >= exp_lin[g]) ? lines_i - exp_lin[g] : exp_lin[g] - lines_i;

    assert_nearest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (best_dh < dh[g]) || ((best_dh == dh[g]) && (best_dv <= dv[g])));
  end

  always_comb begin
    best_dh = dh[0];
    best_dv = dv[0];
    idx_o   = '0;
    for (int i = 1; i < NMODES; i++) begin
      if ((dh[i] < best_dh) || ((dh[i] == best_dh) && (dv[i] < best_dv))) begin
        best_dh = dh[i];
        best_dv = dv[i];
        idx_o   = IW'(i);
      end
    end
  end

  assign ok_o = (int'(best_dh) <= HTOL) && (int'(best_dv) <= VTOL);
endmodule

// File: rtl/smc_qualify.sv
// Frame-by-frame agreement counter that drives the lock flag and outputs.
module smc_qualify
  import smc_pkg::*;
#(
  parameter  int QUAL = 3,
  localparam int SW   = $clog2(QUAL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_i,
  input  logic            ok_i,
  input  logic [IW-1:0]   idx_i,
  input  logic            nosig_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o,
  output logic [DIVW-1:0] div_o
);
  logic [SW-1:0]   streak, streak_n;
  logic [IW-1:0]   last_q, last_n;
  logic            valid_n, en;
  logic [DIVW-1:0] div_n;

  assign en = nosig_i || frame_i;

  always_comb begin
    streak_n = streak;
    last_n   = last_q;
    if (nosig_i) begin
      streak_n = '0;
    end else if (frame_i) begin
      if (ok_i && (idx_i == last_q) && (streak != '0))
        streak_n = (streak == SW'(QUAL)) ? streak : streak + 1'b1;
      else if (ok_i) begin
        streak_n = {{(SW-1){1'b0}}, 1'b1};
        last_n   = idx_i;
      end else
        streak_n = '0;
    end
    valid_n = (streak_n == SW'(QUAL));
    div_n   = DIVW'(mode_htotal(int'(last_n)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak  <= '0;
      last_q  <= '0;
      valid_o <= 1'b0;
      div_o   <= '0;
    end else if (en) begin
      streak  <= streak_n;
      last_q  <= last_n;
      valid_o <= valid_n;
      div_o   <= div_n;
    end
  end

  assign idx_o = last_q;

  assert_valid_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(valid_o) |-> $past(frame_i || nosig_i));
  assert_idx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> $stable(idx_o));
  assert_nosig_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nosig_i |=> !valid_o);
endmodule

// File: rtl/sync_mode_classifier.sv
module sync_mode_classifier
  import smc_pkg::*;
#(
  parameter int REF_KHZ     = 27000,
  parameter int HTOL        = 4,
  parameter int VTOL        = 4,
  parameter int HMAX        = 4095,
  parameter int VMAX        = 2047,
  parameter int QUAL_FRAMES = 3,
  parameter int PLW         = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsync_in,
  input  logic            vsync_in,
  output logic [IW-1:0]   mode_idx_o,
  output logic            valid_o,
  output logic            no_signal_o,
  output logic [DIVW-1:0] line_total_o
);
  localparam int HW = $clog2(HMAX + 1);
  localparam int VW = $clog2(VMAX + 1);

  logic          rs1, rs2;
  logic          hs_edge, vs_edge, frame, ok;
  logic [HW-1:0] per;
  logic [VW-1:0] lines;
  logic [IW-1:0] cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end

  smc_sync_edge #(.PLW(PLW)) u_hs (
    .clk(clk), .rst_n(rs2), .sync_i(hsync_in), .edge_o(hs_edge));
  smc_sync_edge #(.PLW(PLW)) u_vs (
    .clk(clk), .rst_n(rs2), .sync_i(vsync_in), .edge_o(vs_edge));

  smc_meter #(.HMAX(HMAX), .VMAX(VMAX)) u_meter (
    .clk(clk), .rst_n(rs2), .hs_edge_i(hs_edge), .vs_edge_i(vs_edge),
    .per_o(per), .lines_o(lines), .frame_o(frame), .nosig_o(no_signal_o));

  smc_match #(.REF_KHZ(REF_KHZ), .HTOL(HTOL), .VTOL(VTOL), .HW(HW), .VW(VW)) u_match (
    .clk(clk), .rst_n(rs2), .per_i(per), .lines_i(lines), .idx_o(cand), .ok_o(ok));

  smc_qualify #(.QUAL(QUAL_FRAMES)) u_qual (
    .clk(clk), .rst_n(rs2), .frame_i(frame), .ok_i(ok), .idx_i(cand),
    .nosig_i(no_signal_o), .valid_o(valid_o), .idx_o(mode_idx_o), .div_o(line_total_o));
endmodule

// File: tb/sync_mode_classifier_tb.sv
`timescale 1ns/1ps
module sync_mode_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hs, vs;
  logic [1:0]  idx;
  logic        valid, nosig;
  logic [11:0] ltot;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sync_mode_classifier #(
    .REF_KHZ(256), .HTOL(1), .VTOL(4), .HMAX(63), .VMAX(1100),
    .QUAL_FRAMES(3), .PLW(20)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs),
    .mode_idx_o(idx), .valid_o(valid), .no_signal_o(nosig), .line_total_o(ltot));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive whole frames: hsync active for clock 0 of each line, vsync active
  // from line 2 clock 2 to line 5 clock 2.
  task automatic frames(input int per, input int lines, input int hpol,
                        input int vpol, input int n);
    for (int f = 0; f < n; f++)
      for (int l = 0; l < lines; l++)
        for (int c = 0; c < per; c++) begin
          int p;
          p = l * per + c;
          @(negedge clk);
          hs = (c == 0) ? hpol[0] : ~hpol[0];
          vs = (p >= 2 * per + 2 && p < 5 * per + 2) ? vpol[0] : ~vpol[0];
        end
  endtask

  // period, lines, hpol, vpol, exp_valid, exp_idx, exp_total
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{8, 525, 0, 0, 1, 0, 800},   // R6 inverted syncs, R3 exact match
    '{7, 628, 1, 0, 1, 1, 1056},  // R3 period tie broken by line count
    '{4, 960, 1, 1, 0, 0, 0},     // R4 period fits mode 3, lines do not; R8 clears
    '{11, 300, 1, 1, 0, 0, 0},    // R4 period beyond tolerance
    '{5, 809, 1, 1, 1, 2, 1344}   // R3 nearest line count within tolerance
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 199000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hs = 1'b0;
    vs = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 valid", int'(valid), 0);
    chk("R10 no_signal", int'(nosig), 0);
    chk("R10 mode_idx", int'(idx), 0);
    chk("R10 line_total", int'(ltot), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // 1280x960 source: period 4, 1000 lines, positive syncs
    frames(4, 1000, 1, 1, 3);
    chk("R7 no lock before three agreeing frames", int'(valid), 0);
    frames(4, 1000, 1, 1, 2);
    chk("R7 lock after three frames", int'(valid), 1);
    chk("R1 R2 mode index", int'(idx), 3);
    chk("R5 line total is 1800", int'(ltot), 1800);
    chk("R9 no_signal low with sync", int'(nosig), 0);

    for (int v = 0; v < NV; v++) begin
      frames(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 6);
      chk($sformatf("R4 R8 valid vec%0d", v), int'(valid), VEC[v][4]);
      chk($sformatf("R9 no_signal vec%0d", v), int'(nosig), 0);
      if (VEC[v][4] == 1) begin
        chk($sformatf("R3 R6 index vec%0d", v), int'(idx), VEC[v][5]);
        chk($sformatf("R5 line total vec%0d", v), int'(ltot), VEC[v][6]);
      end
    end

    // hsync stops: period counter saturates
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      hs = 1'b0;
      vs = 1'b0;
    end
    chk("R9 no_signal on stalled hsync", int'(nosig), 1);
    chk("R9 valid cleared", int'(valid), 0);

    // hsync returns without vsync: period part clears, line count saturates
    for (int l = 0; l < 10; l++)
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        hs = (c == 0);
      end
    chk("R9 no_signal clears when hsync returns", int'(nosig), 0);
    for (int l = 0; l < 1200; l++)
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        hs = (c == 0);
      end
    chk("R9 no_signal on missing vsync", int'(nosig), 1);
    chk("R9 valid low on missing vsync", int'(valid), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule